// File: doc/BRIEF.md
# Timer Output-Compare Channel

This block is a single output-compare channel for an up-counting general-purpose timer. It watches the timer's counter value and compares it with its own compare register. From that comparison it produces an active-high reference level and a polarity-adjusted output pin. A set of eight encoded behaviours chooses what a comparison does to the reference: nothing (frozen), set on match, clear on match, toggle on match, hold low, hold high, and two complementary PWM shapes.

The compare value can be written straight into the active register, or it can be held in a shadow register. A held value moves into the active register only when the counter reports an update event, so a PWM period never sees a half-changed threshold. A fast trigger path lets a rising edge on the trigger input act as a compare match in the PWM behaviours. The pin then reacts three clock edges after the edge is first sampled. Configuration arrives on a plain write strobe. A channel-enable input guards the direction field, and a lock-level input freezes the behaviour and preload fields.

Top module: `tmr_oc_channel`

## Requirements
- R1: After reset, `oc_ref_o` and `oc_pin_o` are 0, the behaviour is frozen (0), preload and fast enable are off, and both compare registers hold 0.
- R2: Behaviour code 0 leaves the reference unchanged. Codes 1, 2 and 3 drive it to 1, drive it to 0, or invert it, at the clock edge where `cnt_i` equals the active compare value, and at no other edge.
- R3: Codes 4 and 5 hold the reference at 0 and 1 respectively. The change appears at the second clock edge after the write strobe is presented: the first edge stores the code and the second updates the reference.
- R4: Code 6 gives reference 1 while `cnt_i` is below the active compare value and 0 otherwise; code 7 gives the inverse. The reference is registered one edge after the counter value is presented.
- R5: In codes 6 and 7 the reference is reloaded from the comparison only when the comparison result changes, or when the behaviour code has just changed into 6 or 7; otherwise it holds its value.
- R6: With preload off, a compare write takes effect at the next clock edge and updates both the active and the shadow register.
- R7: With preload on, a compare write reaches only the shadow register. On each cycle with `upd_i` high, the shadow register is copied into the active register. If a write and an update fall in the same cycle, the active register receives the shadow value from before the write.
- R8: `oc_pin_o` equals the reference XOR the polarity bit, registered one edge later (polarity 1 inverts).
- R9: With fast enable set in code 6 or 7, a 0-to-1 transition of `trig_i` forces the reference to 1 (code 6) or 0 (code 7) regardless of the comparison. `oc_pin_o` shows the result after the third rising edge, counting the first edge that samples `trig_i` high.
- R10: A trigger edge has no effect on the reference when fast enable is clear, or when the behaviour code is 0 to 5.
- R11: The direction bit (0 = output, 1 = input) is stored only when `chan_en_i` is 0. While it is 1, the reference is held at 0 and matches are ignored.
- R12: While `lock_lvl_i` equals 3 and the direction is output, writes leave the behaviour code and the preload enable unchanged. Fast enable, polarity and direction still follow their own rules.
- R13: When a fast trigger edge and a change of the comparison result reach the reference in the same cycle, the trigger's forced level wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_i | input | CNT_W | Counter value of the timer |
| upd_i | input | 1 | Update-event strobe, one cycle |
| trig_i | input | 1 | Trigger input; rising edge is active |
| chan_en_i | input | 1 | Channel enable; 1 blocks direction writes |
| lock_lvl_i | input | LOCK_W | Lock level; value 3 freezes behaviour and preload fields |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_mode_i | input | 3 | Behaviour code 0..7 |
| cfg_pe_i | input | 1 | Preload enable |
| cfg_fe_i | input | 1 | Fast trigger enable |
| cfg_dir_i | input | 1 | Direction: 0 output, 1 input |
| cfg_pol_i | input | 1 | Pin polarity: 1 inverts |
| ccr_wr_i | input | 1 | Compare value write strobe |
| ccr_data_i | input | CNT_W | Compare value to write |
| oc_ref_o | output | 1 | Active-high reference level |
| oc_pin_o | output | 1 | Polarity-adjusted output pin |

## Verification
The fast trigger and the PWM comparison can both try to update the reference in the same cycle. The bench runs code 7 with the counter below the threshold and raises the trigger. In the cycle when the detected edge reaches the reference logic, it moves the counter above the threshold, so the comparison flips at that same edge. The bench then requires that the reference stays at the trigger's forced low level and remains there while the comparison result holds steady. A second collision, a compare write landing together with an update event under preload, is judged by whether the old shadow value governs the next PWM level.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN = 3'd0,
    OCM_SET    = 3'd1,
    OCM_CLR    = 3'd2,
    OCM_TOG    = 3'd3,
    OCM_LOW    = 3'd4,
    OCM_HIGH   = 3'd5,
    OCM_PWM_A  = 3'd6,
    OCM_PWM_B  = 3'd7
  } ocm_e;

  typedef struct packed {
    ocm_e mode;
    logic pe;
    logic fe;
    logic dir;
    logic pol;
  } oc_cfg_t;

  localparam oc_cfg_t CFG_RESET = '{mode: OCM_FROZEN, pe: 1'b0, fe: 1'b0, dir: 1'b0, pol: 1'b0};

  function automatic logic is_pwm(input ocm_e m);
    return (m == OCM_PWM_A) || (m == OCM_PWM_B);
  endfunction

endpackage

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en_i,
  input  logic [LOCK_W-1:0] lock_lvl_i,
  input  logic              cfg_wr_i,
  input  oc_cfg_t           cfg_in_i,
  input  logic              ccr_wr_i,
  input  logic [CNT_W-1:0]  ccr_data_i,
  input  logic              upd_i,
  output oc_cfg_t           cfg_o,
  output logic [CNT_W-1:0]  ccr_act_o,
  output logic [CNT_W-1:0]  ccr_shd_o
);

  localparam logic [LOCK_W-1:0] LOCK_FULL = LOCK_W'(3);

  oc_cfg_t          cfg_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] shd_q;
  logic             lock_hold;

  // Behaviour and preload fields freeze at the top lock level for an output channel.
  assign lock_hold = (lock_lvl_i == LOCK_FULL) && !cfg_q.dir;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RESET;
    end else if (cfg_wr_i) begin
      if (!lock_hold) begin
        cfg_q.mode <= cfg_in_i.mode;
        cfg_q.pe   <= cfg_in_i.pe;
      end
      if (!chan_en_i) begin
        cfg_q.dir <= cfg_in_i.dir;
      end
      cfg_q.fe  <= cfg_in_i.fe;
      cfg_q.pol <= cfg_in_i.pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shd_q <= '0;
    end else if (ccr_wr_i) begin
      shd_q <= ccr_data_i;
    end
  end

  // Direct write when preload is off; shadow transfer on update when it is on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= '0;
    end else if (!cfg_q.pe) begin
      if (ccr_wr_i) act_q <= ccr_data_i;
    end else if (upd_i) begin
      act_q <= shd_q;
    end
  end

  assign cfg_o     = cfg_q;
  assign ccr_act_o = act_q;
  assign ccr_shd_o = shd_q;

endmodule

// File: rtl/tmr_oc_trig.sv
module tmr_oc_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic edge_o
);

  logic samp_q;
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samp_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      samp_q <= trig_i;
      prev_q <= samp_q;
    end
  end

  // One cycle wide pulse after the first edge that samples the input high.
  assign edge_o = samp_q && !prev_q;

endmodule

// File: rtl/tmr_oc_ref.sv
module tmr_oc_ref
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ccr_act_i,
  input  oc_cfg_t          cfg_i,
  input  logic             trig_edge_i,
  output logic             ref_o
);

  logic ref_q;
  logic ref_nxt;
  logic hit;
  logic below;
  logic below_q;
  ocm_e mode_prev_q;
  logic pwm_entry;
  logic pwm_lvl;
  logic fast_lvl;

  assign hit       = (cnt_i == ccr_act_i);
  assign below     = (cnt_i < ccr_act_i);
  assign pwm_entry = (mode_prev_q != cfg_i.mode);
  assign pwm_lvl   = (cfg_i.mode == OCM_PWM_A) ? below : !below;
  assign fast_lvl  = (cfg_i.mode == OCM_PWM_A);

  always_comb begin
    ref_nxt = ref_q;
    if (cfg_i.dir) begin
      ref_nxt = 1'b0;
    end else begin
      unique case (cfg_i.mode)
        OCM_FROZEN: ref_nxt = ref_q;
        OCM_SET:    if (hit) ref_nxt = 1'b1;
        OCM_CLR:    if (hit) ref_nxt = 1'b0;
        OCM_TOG:    if (hit) ref_nxt = !ref_q;
        OCM_LOW:    ref_nxt = 1'b0;
        OCM_HIGH:   ref_nxt = 1'b1;
        OCM_PWM_A,
        OCM_PWM_B: begin
          if (cfg_i.fe && trig_edge_i) begin
            ref_nxt = fast_lvl;
          end else if (pwm_entry || (below != below_q)) begin
            ref_nxt = pwm_lvl;
          end
        end
        default:    ref_nxt = ref_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q       <= 1'b0;
      below_q     <= 1'b0;
      mode_prev_q <= OCM_FROZEN;
    end else begin
      ref_q       <= ref_nxt;
      below_q     <= below;
      mode_prev_q <= cfg_i.mode;
    end
  end

  assign ref_o = ref_q;

endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
  import tmr_oc_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              upd_i,
  input  logic              trig_i,
  input  logic              chan_en_i,
  input  logic [LOCK_W-1:0] lock_lvl_i,
  input  logic              cfg_wr_i,
  input  logic [2:0]        cfg_mode_i,
  input  logic              cfg_pe_i,
  input  logic              cfg_fe_i,
  input  logic              cfg_dir_i,
  input  logic              cfg_pol_i,
  input  logic              ccr_wr_i,
  input  logic [CNT_W-1:0]  ccr_data_i,
  output logic              oc_ref_o,
  output logic              oc_pin_o
);

  oc_cfg_t          cfg_in;
  oc_cfg_t          cfg_q;
  logic [CNT_W-1:0] ccr_act;
  logic [CNT_W-1:0] ccr_shd;
  logic             trig_edge;
  logic             ref_w;
  logic             pin_q;
  logic [2:0]       mode_q;
  logic             pe_q;
  logic             dir_q;
  logic             pol_q;

  assign cfg_in = '{mode: ocm_e'(cfg_mode_i), pe: cfg_pe_i, fe: cfg_fe_i,
                    dir: cfg_dir_i, pol: cfg_pol_i};

  tmr_oc_regs #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .chan_en_i  (chan_en_i),
    .lock_lvl_i (lock_lvl_i),
    .cfg_wr_i   (cfg_wr_i),
    .cfg_in_i   (cfg_in),
    .ccr_wr_i   (ccr_wr_i),
    .ccr_data_i (ccr_data_i),
    .upd_i      (upd_i),
    .cfg_o      (cfg_q),
    .ccr_act_o  (ccr_act),
    .ccr_shd_o  (ccr_shd)
  );

  tmr_oc_trig trig_i_u (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (trig_i),
    .edge_o (trig_edge)
  );

  tmr_oc_ref #(.CNT_W(CNT_W)) ref_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cnt_i       (cnt_i),
    .ccr_act_i   (ccr_act),
    .cfg_i       (cfg_q),
    .trig_edge_i (trig_edge),
    .ref_o       (ref_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= ref_w ^ cfg_q.pol;
  end

  assign mode_q   = cfg_q.mode;
  assign pe_q     = cfg_q.pe;
  assign dir_q    = cfg_q.dir;
  assign pol_q    = cfg_q.pol;
  assign oc_ref_o = ref_w;
  assign oc_pin_o = pin_q;

endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk #(
  parameter int CNT_W  = 16,
  parameter int LOCK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              upd_i,
  input logic              chan_en_i,
  input logic [LOCK_W-1:0] lock_lvl_i,
  input logic              cfg_wr_i,
  input logic              ccr_wr_i,
  input logic [CNT_W-1:0]  ccr_data_i,
  input logic [2:0]        mode_q,
  input logic              pe_q,
  input logic              dir_q,
  input logic              pol_q,
  input logic [CNT_W-1:0]  ccr_act,
  input logic [CNT_W-1:0]  ccr_shd,
  input logic              oc_ref_o,
  input logic              oc_pin_o
);

  AST_FROZEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd0 && !dir_q) |=> $stable(oc_ref_o)); // R2

  AST_SET_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd1 && !dir_q && cnt_i == ccr_act) |=> oc_ref_o); // R2

  AST_CLR_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd2 && !dir_q && cnt_i == ccr_act) |=> !oc_ref_o); // R2

  AST_FORCED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd4 && !dir_q) |=> !oc_ref_o); // R3

  AST_FORCED_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 3'd5 && !dir_q) |=> oc_ref_o); // R3

  AST_DIRECT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ccr_wr_i && !pe_q) |=> (ccr_act == $past(ccr_data_i))); // R6

  AST_SHADOW_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_i && pe_q) |=> (ccr_act == $past(ccr_shd))); // R7

  AST_ACTIVE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_i && pe_q) |=> $stable(ccr_act)); // R7

  AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (oc_pin_o == ($past(oc_ref_o) ^ $past(pol_q)))); // R8

  AST_INPUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dir_q |=> !oc_ref_o); // R11

  AST_DIR_GUARDED: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_i |=> $stable(dir_q)); // R11

  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && lock_lvl_i == LOCK_W'(3) && !dir_q) |=> ($stable(mode_q) && $stable(pe_q))); // R12

endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_i      (cnt_i),
  .upd_i      (upd_i),
  .chan_en_i  (chan_en_i),
  .lock_lvl_i (lock_lvl_i),
  .cfg_wr_i   (cfg_wr_i),
  .ccr_wr_i   (ccr_wr_i),
  .ccr_data_i (ccr_data_i),
  .mode_q     (mode_q),
  .pe_q       (pe_q),
  .dir_q      (dir_q),
  .pol_q      (pol_q),
  .ccr_act    (ccr_act),
  .ccr_shd    (ccr_shd),
  .oc_ref_o   (oc_ref_o),
  .oc_pin_o   (oc_pin_o)
);

// File: tb/tmr_oc_channel_tb_top.sv
module tmr_oc_channel_tb_top;

  localparam int CNT_W  = 16;
  localparam int LOCK_W = 2;
  localparam int NV     = 12;

  // {code[2:0], polarity, compare[15:0], counter[15:0], expected reference}
  localparam logic [36:0] VEC [NV] = '{
    {3'd6, 1'b0, 16'd10,     16'd5,     1'b1},
    {3'd6, 1'b0, 16'd10,     16'd10,    1'b0},
    {3'd6, 1'b0, 16'd10,     16'd12,    1'b0},
    {3'd7, 1'b0, 16'd10,     16'd5,     1'b0},
    {3'd7, 1'b0, 16'd10,     16'd10,    1'b1},
    {3'd7, 1'b1, 16'd10,     16'd3,     1'b0},
    {3'd5, 1'b0, 16'd10,     16'd3,     1'b1},
    {3'd4, 1'b1, 16'd10,     16'd3,     1'b0},
    {3'd6, 1'b1, 16'd0,      16'd0,     1'b0},
    {3'd7, 1'b0, 16'd0,      16'd0,     1'b1},
    {3'd6, 1'b0, 16'hFFFF,   16'hFFFE,  1'b1},
    {3'd6, 1'b0, 16'hFFFF,   16'hFFFF,  1'b0}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [CNT_W-1:0]  cnt_i = '0;
  logic              upd_i = 1'b0;
  logic              trig_i = 1'b0;
  logic              chan_en_i = 1'b0;
  logic [LOCK_W-1:0] lock_lvl_i = '0;
  logic              cfg_wr_i = 1'b0;
  logic [2:0]        cfg_mode_i = '0;
  logic              cfg_pe_i = 1'b0;
  logic              cfg_fe_i = 1'b0;
  logic              cfg_dir_i = 1'b0;
  logic              cfg_pol_i = 1'b0;
  logic              ccr_wr_i = 1'b0;
  logic [CNT_W-1:0]  ccr_data_i = '0;
  logic              oc_ref_o;
  logic              oc_pin_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_oc_channel #(.CNT_W(CNT_W), .LOCK_W(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i), .trig_i(trig_i),
    .chan_en_i(chan_en_i), .lock_lvl_i(lock_lvl_i), .cfg_wr_i(cfg_wr_i),
    .cfg_mode_i(cfg_mode_i), .cfg_pe_i(cfg_pe_i), .cfg_fe_i(cfg_fe_i),
    .cfg_dir_i(cfg_dir_i), .cfg_pol_i(cfg_pol_i), .ccr_wr_i(ccr_wr_i),
    .ccr_data_i(ccr_data_i), .oc_ref_o(oc_ref_o), .oc_pin_o(oc_pin_o)
  );

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, got, exp, $time);
    end
  endtask

  task automatic stepn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [2:0] m, input logic pe, input logic fe,
                        input logic dir, input logic pol);
    cfg_mode_i = m; cfg_pe_i = pe; cfg_fe_i = fe; cfg_dir_i = dir; cfg_pol_i = pol;
    cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
  endtask

  task automatic wr_ccr(input logic [CNT_W-1:0] d);
    ccr_data_i = d; ccr_wr_i = 1'b1;
    @(negedge clk);
    ccr_wr_i = 1'b0;
  endtask

  task automatic pulse_upd();
    upd_i = 1'b1;
    @(negedge clk);
    upd_i = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    cnt_i = 16'd7;
    stepn(3);
    rst_n = 1'b1;
    stepn(1);
    // R1 reset state
    chk("R1", "reference after reset", oc_ref_o, 1'b0);
    chk("R1", "pin after reset", oc_pin_o, 1'b0);
    cnt_i = 16'd0;
    stepn(3);
    chk("R1", "frozen at reset ignores hit", oc_ref_o, 1'b0);
    wr_cfg(3'd1, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(1);
    chk("R1", "compare register resets to zero", oc_ref_o, 1'b1);

    // Vector table: R3, R4, R8
    for (int i = 0; i < NV; i++) begin
      logic [36:0] v;
      v = VEC[i];
      cnt_i = v[16:1];
      ccr_data_i = v[32:17]; ccr_wr_i = 1'b1;
      cfg_mode_i = v[36:34]; cfg_pe_i = 1'b0; cfg_fe_i = 1'b0;
      cfg_dir_i = 1'b0; cfg_pol_i = v[33]; cfg_wr_i = 1'b1;
      @(negedge clk);
      ccr_wr_i = 1'b0; cfg_wr_i = 1'b0;
      stepn(3);
      chk((v[36:34] >= 3'd6) ? "R4" : "R3", $sformatf("vector %0d reference", i), oc_ref_o, v[0]);
      chk("R8", $sformatf("vector %0d pin", i), oc_pin_o, v[0] ^ v[33]);
    end

    // R2 clear and toggle on match
    wr_cfg(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(2);
    wr_ccr(16'd9);
    cnt_i = 16'd3;
    wr_cfg(3'd2, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(3);
    chk("R2", "clear code without hit", oc_ref_o, 1'b1);
    cnt_i = 16'd9;
    stepn(1);
    chk("R2", "clear code on hit", oc_ref_o, 1'b0);
    cnt_i = 16'd4;
    wr_cfg(3'd3, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(2);
    chk("R2", "toggle code idle", oc_ref_o, 1'b0);
    cnt_i = 16'd9;
    stepn(1);
    cnt_i = 16'd4;
    chk("R2", "toggle on first hit", oc_ref_o, 1'b1);
    stepn(3);
    chk("R2", "toggle holds off hit", oc_ref_o, 1'b1);
    cnt_i = 16'd9;
    stepn(1);
    cnt_i = 16'd4;
    chk("R2", "toggle on second hit", oc_ref_o, 1'b0);
    wr_cfg(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(2);
    wr_cfg(3'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    cnt_i = 16'd9;
    stepn(3);
    chk("R2", "frozen keeps level through hits", oc_ref_o, 1'b1);

    // R3 force timing
    cfg_mode_i = 3'd4; cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R3", "force low not yet applied", oc_ref_o, 1'b1);
    stepn(1);
    chk("R3", "force low applied", oc_ref_o, 1'b0);
    cfg_mode_i = 3'd5; cfg_wr_i = 1'b1;
    @(negedge clk);
    cfg_wr_i = 1'b0;
    chk("R3", "force high not yet applied", oc_ref_o, 1'b0);
    stepn(1);
    chk("R3", "force high applied", oc_ref_o, 1'b1);

    // R6 and R7 preload
    cnt_i = 16'd50;
    wr_cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_ccr(16'd30);
    stepn(1);
    chk("R6", "direct compare write", oc_ref_o, 1'b0);
    wr_cfg(3'd6, 1'b1, 1'b0, 1'b0, 1'b0);
    wr_ccr(16'd100);
    stepn(3);
    chk("R7", "shadow write not active", oc_ref_o, 1'b0);
    pulse_upd();
    stepn(1);
    chk("R7", "shadow moved on update", oc_ref_o, 1'b1);
    ccr_data_i = 16'd20; ccr_wr_i = 1'b1; upd_i = 1'b1;
    @(negedge clk);
    ccr_wr_i = 1'b0; upd_i = 1'b0;
    stepn(2);
    chk("R7", "update with write uses old shadow", oc_ref_o, 1'b1);
    pulse_upd();
    stepn(2);
    chk("R7", "later update uses new shadow", oc_ref_o, 1'b0);

    // R12 lock
    lock_lvl_i = 2'd3;
    wr_cfg(3'd5, 1'b1, 1'b0, 1'b0, 1'b0);
    stepn(3);
    chk("R12", "code write ignored under lock", oc_ref_o, 1'b0);
    wr_cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    wr_ccr(16'd90);
    stepn(3);
    chk("R12", "preload clear ignored under lock", oc_ref_o, 1'b0);
    lock_lvl_i = 2'd0;
    pulse_upd();
    stepn(2);
    chk("R7", "locked write went to shadow", oc_ref_o, 1'b1);
    wr_cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9 and R5 fast trigger
    wr_ccr(16'd10);
    wr_cfg(3'd6, 1'b0, 1'b1, 1'b0, 1'b0);
    stepn(2);
    chk("R9", "code 6 above threshold", oc_ref_o, 1'b0);
    trig_i = 1'b1;
    stepn(1);
    chk("R9", "pin after first edge", oc_pin_o, 1'b0);
    stepn(1);
    chk("R9", "pin after second edge", oc_pin_o, 1'b0);
    stepn(1);
    chk("R9", "pin after third edge", oc_pin_o, 1'b1);
    stepn(3);
    chk("R5", "forced level holds while compare steady", oc_ref_o, 1'b1);
    cnt_i = 16'd5;
    stepn(2);
    chk("R5", "compare change to below", oc_ref_o, 1'b1);
    cnt_i = 16'd50;
    stepn(2);
    chk("R5", "compare change to above", oc_ref_o, 1'b0);
    trig_i = 1'b0;
    wr_cfg(3'd7, 1'b0, 1'b1, 1'b0, 1'b0);
    stepn(2);
    chk("R5", "entry into code 7", oc_ref_o, 1'b1);
    trig_i = 1'b1;
    stepn(3);
    chk("R9", "code 7 forced low pin", oc_pin_o, 1'b0);
    chk("R9", "code 7 forced low reference", oc_ref_o, 1'b0);
    trig_i = 1'b0;
    stepn(1);

    // R10 trigger without effect
    wr_cfg(3'd4, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(1);
    wr_cfg(3'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    stepn(1);
    trig_i = 1'b1;
    stepn(5);
    chk("R10", "fast enable in code 1", oc_ref_o, 1'b0);
    trig_i = 1'b0;
    wr_cfg(3'd6, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(2);
    trig_i = 1'b1;
    stepn(5);
    chk("R10", "fast disabled in code 6 reference", oc_ref_o, 1'b0);
    chk("R10", "fast disabled in code 6 pin", oc_pin_o, 1'b0);
    trig_i = 1'b0;
    stepn(1);

    // R13 trigger against compare change
    cnt_i = 16'd5;
    wr_cfg(3'd7, 1'b0, 1'b1, 1'b0, 1'b0);
    stepn(2);
    chk("R13", "code 7 below threshold", oc_ref_o, 1'b0);
    trig_i = 1'b1;
    stepn(1);
    cnt_i = 16'd50;
    stepn(1);
    chk("R13", "trigger beats compare change", oc_ref_o, 1'b0);
    stepn(3);
    chk("R13", "forced level kept after collision", oc_ref_o, 1'b0);
    trig_i = 1'b0;
    cnt_i = 16'd5;
    stepn(2);
    cnt_i = 16'd50;
    stepn(2);
    chk("R13", "compare change later applies", oc_ref_o, 1'b1);

    // R11 direction
    chan_en_i = 1'b1;
    wr_cfg(3'd5, 1'b0, 1'b0, 1'b1, 1'b0);
    stepn(2);
    chk("R11", "direction write blocked while enabled", oc_ref_o, 1'b1);
    chan_en_i = 1'b0;
    wr_cfg(3'd5, 1'b0, 1'b0, 1'b1, 1'b0);
    stepn(1);
    chk("R11", "input direction holds reference low", oc_ref_o, 1'b0);
    cnt_i = 16'd10;
    wr_cfg(3'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    stepn(3);
    chk("R11", "matches ignored as input", oc_ref_o, 1'b0);
    wr_cfg(3'd5, 1'b0, 1'b0, 1'b0, 1'b0);
    stepn(1);
    chk("R11", "back to output", oc_ref_o, 1'b1);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule